// File: doc/BRIEF.md
# Asymmetric Serial Clock Generator

This block derives a serial interface clock from the bus clock. The bus clock first passes through a power-of-two prescaler. Its tick then drives a phase counter that holds the clock in its high half for one programmed number of ticks and in its low half for another. The duty cycle therefore need not be 50%.

The output clock carries the selected idle polarity. Alongside it the block gives one-cycle strobes at each leading (idle-to-active) and trailing (active-to-idle) transition. It also routes those strobes to a sample strobe and a shift strobe according to the clock phase setting, so a neighbouring shifter can use them directly.

A run input starts and stops the clock. When run is low the clock sits at idle and every counter is held cleared. Each new run therefore begins with a complete idle half.

Top module: `asym_sclk_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `sclk_o` equals `cpol_i` and all four strobes are 0.
- R2: While `run_i` is sampled low, `sclk_o` returns to `cpol_i` on the next cycle and no strobe is produced, including when the stop falls in the active half.
- R3: The prescale period is P = 2^S bus cycles, where S is `scale_i`. The active half of each serial clock period (`sclk_o` != `cpol_i`) lasts `hi_ticks_i` × P bus cycles.
- R4: The idle half of each serial clock period (`sclk_o` == `cpol_i`) lasts `lo_ticks_i` × P bus cycles.
- R5: A `scale_i` value above 8 behaves exactly like 8, giving P = 256.
- R6: After `run_i` is first sampled high, the clock first spends a full idle half of `lo_ticks_i` × P cycles. The first `lead_o` then appears on the cycle counted from the first edge that sampled run.
- R7: `lead_o` is high for exactly the one cycle in which `sclk_o` first shows its active level. `trail_o` is high for exactly the one cycle in which `sclk_o` first returns to idle. Neither is ever high on two consecutive cycles, and the two are never high together.
- R8: With `cpha_i` = 0, `sample_o` follows `lead_o` and `shift_o` follows `trail_o`. With `cpha_i` = 1 the two roles swap.
- R9: `cpol_i` = 1 inverts `sclk_o` and leaves the timing of every strobe unchanged.
- R10: A value of 0 in `hi_ticks_i` or `lo_ticks_i` is treated as 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | Clock enable; low returns the clock to idle and clears the counters |
| scale_i | input | 4 | Prescale exponent S; the prescale period is 2^S bus cycles, and values above 8 are clamped to 8 |
| hi_ticks_i | input | 8 | Length of the active half, in prescaled ticks (0 counts as 1) |
| lo_ticks_i | input | 8 | Length of the idle half, in prescaled ticks (0 counts as 1) |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| sclk_o | output | 1 | Serial clock with polarity applied |
| lead_o | output | 1 | One-cycle strobe at the transition to the active level |
| trail_o | output | 1 | One-cycle strobe at the transition to idle |
| sample_o | output | 1 | Strobe on the edge where data is sampled |
| shift_o | output | 1 | Strobe on the edge where data is launched |

## Verification
The clock is run with several settings:
- Equal one-tick halves at no prescaling, which exposes off-by-one errors in the phase counter.
- Unequal halves (3/5 and 2/1), which catch swapped high and low fields.
- A prescale of 4, which separates prescaler faults from phase-counter faults.
- A scale of 9, which shows whether the clamp to 256 works.
- Zero fields, which show whether a zero is promoted to one tick.

Directed measurements cover the half lengths and the delay from start to the first leading edge. A behavioural model is compared on every cycle. Inverted polarity with the second-edge phase separates level inversion from strobe routing. A stop during the active half tests that the clock returns to idle without a stray trailing strobe.

// File: rtl/sclk_gen_pkg.sv
// Package: shared constants and helpers for the asymmetric serial clock generator.
// Assumes the scale exponent is unsigned and clamped to SCALE_MAX_DEF.
package sclk_gen_pkg;

    localparam int SCALE_W_DEF   = 4;
    localparam int SCALE_MAX_DEF = 8;
    localparam int CNT_W_DEF     = 8;

    // Edge routing selected by the phase setting
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_sel_e;

    // Strobe bundle passed from the phase counter to the output stage
    typedef struct packed {
        logic lead;
        logic trail;
    } edge_pulse_t;

endpackage

// File: rtl/sclk_gen_prescale.sv
// Module: power-of-two prescaler.
// Produces a one-cycle tick every 2^S bus cycles while run is high; S is clamped to SCALE_MAX.
// Assumes: when run is low the count is held at zero, so a restart always takes a full period.
module sclk_gen_prescale #(
    parameter int SCALE_W   = 4,
    parameter int SCALE_MAX = 8,
    localparam int PRE_W    = (SCALE_MAX < 1) ? 1 : SCALE_MAX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic               tick_o
);

    generate
        if (SCALE_MAX == 0) begin : g_no_div
            // With no division allowed, every running cycle is a tick
            assign tick_o = run_i;
        end else begin : g_div
            logic [PRE_W-1:0] pre_q;
            logic [PRE_W:0]   span;
            logic [PRE_W-1:0] mask;
            logic [SCALE_W-1:0] s_eff;

            // Clamp the exponent and build the terminal count
            always_comb begin
                s_eff = (scale_i > SCALE_W'(SCALE_MAX)) ? SCALE_W'(SCALE_MAX) : scale_i;
                span  = (PRE_W+1)'(1) << s_eff;
                mask  = PRE_W'(span - (PRE_W+1)'(1));
            end

            assign tick_o = run_i && (pre_q >= mask);

            // Count bus cycles up to the terminal value, cleared when stopped
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i) begin
                    pre_q <= '0;
                end else if (tick_o) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + PRE_W'(1);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sclk_gen_phase.sv
// Module: half-period counter.
// Counts prescaled ticks in the current half and toggles the raw clock when the half ends.
// Emits registered one-cycle strobes in the same cycle the raw level changes.
// Assumes: a zero length counts as one tick; the raw clock starts in its low (idle) half.
module sclk_gen_phase #(
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_i,
    input  logic                      tick_i,
    input  logic [CNT_W-1:0]          hi_len_i,
    input  logic [CNT_W-1:0]          lo_len_i,
    output logic                      raw_o,
    output sclk_gen_pkg::edge_pulse_t edge_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hi_eff;
    logic [CNT_W-1:0] lo_eff;
    logic [CNT_W-1:0] last;
    logic             act_q;
    logic             lead_q;
    logic             trail_q;
    logic             half_done;

    // Promote zero lengths to one and pick the limit of the current half
    always_comb begin
        hi_eff    = (hi_len_i == '0) ? CNT_W'(1) : hi_len_i;
        lo_eff    = (lo_len_i == '0) ? CNT_W'(1) : lo_len_i;
        last      = act_q ? (hi_eff - CNT_W'(1)) : (lo_eff - CNT_W'(1));
        half_done = tick_i && (cnt_q >= last);
    end

    // Advance the tick count, flip the half at its end and raise the matching strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q   <= '0;
            act_q   <= 1'b0;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            lead_q  <= half_done && !act_q;
            trail_q <= half_done && act_q;
            if (half_done) begin
                cnt_q <= '0;
                act_q <= !act_q;
            end else if (tick_i) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign raw_o        = act_q;
    assign edge_o.lead  = lead_q;
    assign edge_o.trail = trail_q;

endmodule

// File: rtl/sclk_gen_out.sv
// Module: output stage.
// Applies the idle polarity to the raw clock and routes edge strobes to sample and shift roles.
// Assumes the strobes arrive already one cycle wide and aligned with the raw level change.
module sclk_gen_out (
    input  logic                      raw_i,
    input  sclk_gen_pkg::edge_pulse_t edge_i,
    input  logic                      cpol_i,
    input  logic                      cpha_i,
    output logic                      sclk_o,
    output logic                      lead_o,
    output logic                      trail_o,
    output logic                      sample_o,
    output logic                      shift_o
);
    import sclk_gen_pkg::*;

    phase_sel_e ph;

    // Apply polarity and assign the sampling edge per phase setting
    always_comb begin
        ph      = phase_sel_e'(cpha_i);
        sclk_o  = raw_i ^ cpol_i;
        lead_o  = edge_i.lead;
        trail_o = edge_i.trail;
        if (ph == PH_FIRST) begin
            sample_o = edge_i.lead;
            shift_o  = edge_i.trail;
        end else begin
            sample_o = edge_i.trail;
            shift_o  = edge_i.lead;
        end
    end

endmodule

// File: rtl/asym_sclk_gen.sv
// Module: asymmetric serial clock generator (top).
// Chains the prescaler, the half-period counter and the output stage.
// Assumes the settings are stable while running; a change takes effect at the next tick.
module asym_sclk_gen #(
    parameter int SCALE_W   = sclk_gen_pkg::SCALE_W_DEF,
    parameter int SCALE_MAX = sclk_gen_pkg::SCALE_MAX_DEF,
    parameter int CNT_W     = sclk_gen_pkg::CNT_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic [CNT_W-1:0]   hi_ticks_i,
    input  logic [CNT_W-1:0]   lo_ticks_i,
    input  logic               cpol_i,
    input  logic               cpha_i,
    output logic               sclk_o,
    output logic               lead_o,
    output logic               trail_o,
    output logic               sample_o,
    output logic               shift_o
);

    logic                      tick;
    logic                      raw;
    sclk_gen_pkg::edge_pulse_t edges;

    sclk_gen_prescale #(
        .SCALE_W  (SCALE_W),
        .SCALE_MAX(SCALE_MAX)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_i),
        .scale_i(scale_i),
        .tick_o (tick)
    );

    sclk_gen_phase #(
        .CNT_W(CNT_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_i),
        .tick_i  (tick),
        .hi_len_i(hi_ticks_i),
        .lo_len_i(lo_ticks_i),
        .raw_o   (raw),
        .edge_o  (edges)
    );

    sclk_gen_out u_out (
        .raw_i   (raw),
        .edge_i  (edges),
        .cpol_i  (cpol_i),
        .cpha_i  (cpha_i),
        .sclk_o  (sclk_o),
        .lead_o  (lead_o),
        .trail_o (trail_o),
        .sample_o(sample_o),
        .shift_o (shift_o)
    );

endmodule

// File: rtl/asym_sclk_gen_chk.sv
// Module: property checker for the clock generator, bound to the top.
// Observes ports only.
module asym_sclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic run_i,
    input logic cpol_i,
    input logic cpha_i,
    input logic sclk_o,
    input logic lead_o,
    input logic trail_o,
    input logic sample_o,
    input logic shift_o
);

    // R2: a stop returns the clock to idle with no strobe
    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!lead_o && !trail_o));

    // R7: a leading strobe coincides with the active level
    assert_lead_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lead_o |-> (sclk_o != cpol_i));

    // R7: a trailing strobe coincides with the idle level
    assert_trail_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trail_o |-> (sclk_o == cpol_i));

    // R7: strobes last one cycle and never overlap
    assert_lead_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lead_o |=> !lead_o);
    assert_trail_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trail_o |=> !trail_o);
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lead_o, trail_o}));

    // R7: while running, every level change is marked by a strobe
    assert_change_marked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && $stable(cpol_i) && (sclk_o != $past(sclk_o)))
            |-> (lead_o || trail_o));

    // R8: sample and shift strobes come only from clock edges and never together
    assert_sample_from_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (lead_o || trail_o));
    assert_sample_shift_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_o, shift_o}));

endmodule

bind asym_sclk_gen asym_sclk_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_i),
    .cpol_i  (cpol_i),
    .cpha_i  (cpha_i),
    .sclk_o  (sclk_o),
    .lead_o  (lead_o),
    .trail_o (trail_o),
    .sample_o(sample_o),
    .shift_o (shift_o)
);

// File: tb/asym_sclk_gen_test.sv
// Bench: behavioural reference model compared on every clock, plus directed timing measurements.
module asym_sclk_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [3:0] scale = 4'd0;
    logic [7:0] hi = 8'd1;
    logic [7:0] lo = 8'd1;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       sclk, lead, trail, sample, shift;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    int m_pre = 0;
    int m_cnt = 0;
    bit m_act = 1'b0;
    bit m_lead = 1'b0;
    bit m_trail = 1'b0;

    always #5 clk = ~clk;

    asym_sclk_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .scale_i   (scale),
        .hi_ticks_i(hi),
        .lo_ticks_i(lo),
        .cpol_i    (cpol),
        .cpha_i    (cpha),
        .sclk_o    (sclk),
        .lead_o    (lead),
        .trail_o   (trail),
        .sample_o  (sample),
        .shift_o   (shift)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            if (errors < 30)
                $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model: integer tick and half-length bookkeeping per the requirements
    always @(posedge clk) begin
        cycles++;
        if (!rst_n || !run) begin
            m_pre = 0; m_cnt = 0; m_act = 0; m_lead = 0; m_trail = 0;
        end else begin
            int s, p, len;
            bit tk;
            s  = (scale > 8) ? 8 : int'(scale);           // R5
            p  = 1 << s;                                   // R3, R4
            tk = (m_pre >= p - 1);
            m_pre = tk ? 0 : m_pre + 1;
            m_lead = 0; m_trail = 0;
            if (tk) begin
                len = m_act ? int'(hi) : int'(lo);
                if (len == 0) len = 1;                     // R10
                if (m_cnt >= len - 1) begin
                    m_cnt = 0;
                    m_act = !m_act;
                    if (m_act) m_lead = 1; else m_trail = 1;
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(sclk == (m_act ^ cpol), "R9 sclk level", int'(sclk), int'(m_act ^ cpol));
            check(lead == m_lead, "R7 lead strobe", int'(lead), int'(m_lead));
            check(trail == m_trail, "R7 trail strobe", int'(trail), int'(m_trail));
            check(sample == (cpha ? m_trail : m_lead), "R8 sample strobe",
                  int'(sample), int'(cpha ? m_trail : m_lead));
            check(shift == (cpha ? m_lead : m_trail), "R8 shift strobe",
                  int'(shift), int'(cpha ? m_lead : m_trail));
        end
    end

    // Watchdog
    initial begin
        wait (cycles > 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Measure active and idle half lengths of one full period (R3, R4)
    task automatic measure(input int exp_hi, input int exp_lo, input string tag);
        int n;
        n = 0;
        while (!lead && n < 5000) begin @(negedge clk); n++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!trail && n < 5000);
        check(n == exp_hi, {tag, " R3 active half"}, n, exp_hi);
        n = 0;
        do begin @(negedge clk); n++; end while (!lead && n < 5000);
        check(n == exp_lo, {tag, " R4 idle half"}, n, exp_lo);
    endtask

    // Start from stopped and measure the delay to the first leading strobe (R6)
    task automatic start_delay(input int exp_n);
        int n;
        n = 0;
        run = 1'b1;
        do begin @(negedge clk); n++; end while (!lead && n < 5000);
        check(n == exp_n, "R6 first leading edge", n, exp_n);
    endtask

    task automatic stop_clock();
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        check(sclk == 1'b0 && !lead && !trail && !sample && !shift, "R1 in reset",
              int'({sclk, lead, trail, sample, shift}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk == cpol && !lead && !trail, "R1 after reset", int'(sclk), int'(cpol));

        // Equal single-tick halves, no prescale
        scale = 0; hi = 1; lo = 1;
        start_delay(1);
        measure(1, 1, "1/1");
        stop_clock();

        // Unequal halves
        hi = 3; lo = 5;
        start_delay(5);
        measure(3, 5, "3/5");
        stop_clock();

        // Prescale by 4 with 2/1 halves
        scale = 2; hi = 2; lo = 1;
        start_delay(4);
        measure(8, 4, "s2");
        stop_clock();

        // R5: scale 9 behaves as 8
        scale = 9; hi = 1; lo = 1;
        start_delay(256);
        measure(256, 256, "R5 clamp");
        stop_clock();

        // R10: zero fields count as one tick
        scale = 1; hi = 0; lo = 0;
        start_delay(2);
        measure(2, 2, "R10 zero");
        stop_clock();

        // R9 and R8: inverted polarity, second-edge phase
        cpol = 1; cpha = 1; scale = 0; hi = 2; lo = 3;
        @(negedge clk);
        check(sclk == 1'b1, "R9 idle high", int'(sclk), 1);
        start_delay(3);
        check(sclk == 1'b0 && shift && !sample, "R8 shift on leading",
              int'({sclk, shift, sample}), 2);
        measure(2, 3, "R9 inv");
        stop_clock();

        // R2: stop during the active half, no stray trailing strobe
        cpol = 0; cpha = 0; hi = 6; lo = 1;
        start_delay(1);
        @(negedge clk);
        run = 1'b0;
        begin
            bit seen;
            seen = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (lead || trail) seen = 1;
            end
            check(!seen, "R2 no strobe after stop", int'(seen), 0);
            check(sclk == 1'b0, "R2 idle after stop", int'(sclk), 0);
        end
        // Restart takes a full idle half again
        lo = 4;
        start_delay(4);
        measure(6, 4, "R2 restart");
        stop_clock();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule